// File: doc/BRIEF.md
# SMIC Host Transaction Controller

This block drives one request/response exchange with a management controller that sits behind a three-register byte interface. The three registers are data at offset 0, control/status at offset 1 (control when written, status when read) and flags at offset 2. A local agent starts an exchange by pulsing `start` with a request length. The controller fetches request bytes one at a time from a buffer owned by the agent. It sends them over the register interface, then reads the response back and hands each byte to the agent through a write port. At the end it reports success (`done`) or a hard failure (`fail`), each as a one-cycle pulse.

Every protocol step follows the same pattern. The controller writes a control code, in some steps also writes a data byte, and then writes the flags register back with its busy bit set. On the next poll it waits until busy is clear and checks that the status register shows the echo it expects. Any wrong echo, a non-zero error byte or a stalled step restarts the whole exchange from its first command. After three restarts the controller gives up. While no exchange is running, it keeps polling the flags register and raises `attn` when the far side signals that it has a message waiting.

Top module: `smic_host_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `attn`, `start_rej`, `resp_len` and `resp_trunc` are 0 and no register is written.
- R2: A `start` with `req_len` below 2 or above MAX_LEN, or while `busy` is 1 (except during the one-cycle failure report), pulses `start_rej` one cycle later and does not alter the exchange in progress.
- R3: Every poll reads the flags register (offset 2) first. While its busy bit (bit 0) reads 1, no other register is read and none is written.
- R4: Each command is a control write at offset 1, optionally followed by a data write at offset 0, and then a flags write at offset 2 whose bit 0 is 1.
- R5: The request phase sends control 0x40 and requires status 0xC0. It then sends 0x41 with byte 0, 0x42 with each middle byte and 0x43 with the last byte, expecting echoes 0xC1, 0xC2 and 0xC3. A 0x42 or 0x43 command is only issued while flags bit 6 (send ready) is 1.
- R6: After echo 0xC3, the data register holds an error byte. A non-zero value starts recovery. On zero, the controller waits for flags bit 7 (receive ready) before sending 0x44.
- R7: In the response phase, status 0xC4 or 0xC5 with bit 7 set makes the controller read one byte and send 0x45. Status 0xC6 makes it read the final byte and send 0x46. Status 0xC0 with a zero error byte then gives a `done` pulse, with `resp_len` equal to the number of bytes stored.
- R8: Recovery resets the byte counters and restarts at control 0x40. The fourth recovery since `start` instead ends the exchange with a `fail` pulse, and the controller returns to idle.
- R9: If no step completes within TMO_US microseconds while an exchange is active, recovery starts. A flags register whose busy bit never clears therefore ends in `fail`.
- R10: Response bytes beyond MAX_LEN are still read from the data register but are not stored. `resp_len` stops at MAX_LEN and `resp_trunc` becomes 1.
- R11: When idle, `attn` follows flags bit 2 whenever busy reads 0. Flag bits 4 and 3 have no effect.
- R12: `done` and `fail` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an exchange |
| req_len | input | LEN_W | Request length in bytes |
| start_rej | output | 1 | Start refused (pulse) |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | Exchange completed (pulse) |
| fail | output | 1 | Retries exhausted (pulse) |
| attn | output | 1 | Message waiting at far side |
| req_addr | output | LEN_W | Index of the request byte being fetched |
| req_data | input | 8 | Request byte at `req_addr` |
| resp_we | output | 1 | Store response byte |
| resp_addr | output | LEN_W | Response byte index |
| resp_data | output | 8 | Response byte |
| resp_len | output | LEN_W | Response bytes stored |
| resp_trunc | output | 1 | Response exceeded MAX_LEN |
| bus_addr | output | 2 | Register offset |
| bus_rd | output | 1 | Register read strobe |
| bus_wr | output | 1 | Register write strobe |
| bus_wdata | output | 8 | Register write data |
| bus_rdata | input | 8 | Register read data, valid in the strobe cycle |

## Verification
The hardest state to reach is the retry boundary, where exactly three recoveries must still succeed and a fourth must fail. Recoveries from different causes add up, so the count does not reset between them. The bench's register model can be set to corrupt a given number of get-status echoes, return non-zero error bytes after a given number of write-end and read-end steps, or hold the busy bit forever. Mixing these knobs within one exchange drives the counter to the limit through wrong echoes, error bytes and timeouts. Separate gating of the ready bits after each busy release makes the controller poll in its waiting states.

// File: rtl/smic_pkg.sv
package smic_pkg;

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_FLG  = 2'd2;

    localparam int F_BSY  = 0;
    localparam int F_MSG  = 2;
    localparam int F_TXR  = 6;
    localparam int F_RXR  = 7;

    localparam logic [7:0] CC_GET = 8'h40;
    localparam logic [7:0] CC_WRS = 8'h41;
    localparam logic [7:0] CC_WRN = 8'h42;
    localparam logic [7:0] CC_WRE = 8'h43;
    localparam logic [7:0] CC_RDS = 8'h44;
    localparam logic [7:0] CC_RDN = 8'h45;
    localparam logic [7:0] CC_RDE = 8'h46;

    localparam logic [7:0] SC_RDY = 8'hC0;
    localparam logic [7:0] SC_WRS = 8'hC1;
    localparam logic [7:0] SC_WRN = 8'hC2;
    localparam logic [7:0] SC_WRE = 8'hC3;
    localparam logic [7:0] SC_RDS = 8'hC4;
    localparam logic [7:0] SC_RDN = 8'hC5;
    localparam logic [7:0] SC_RDE = 8'hC6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_GET, ST_CHK_RDY, ST_WR_FIRST, ST_WR_MID, ST_WR_LAST,
        ST_TURN, ST_RD_FIRST, ST_RD_MID, ST_RD_LAST, ST_DEAD
    } phase_e;

    typedef enum logic [2:0] {
        MS_POLL, MS_STATUS, MS_RDDATA, MS_CTRL, MS_WDATA, MS_FLAGS
    } micro_e;

    typedef struct packed {
        logic       recover;
        logic       hold;
        logic       rd_data;
        logic       chk_err;
        logic [7:0] code;
        logic       wr_data;
        phase_e     nxt;
    } step_t;

    function automatic step_t decide(phase_e ph, logic [7:0] sts,
                                     logic [7:0] flg, logic last);
        step_t s;
        logic [7:0] echo;
        s.recover = 1'b0;
        s.hold    = 1'b0;
        s.rd_data = 1'b0;
        s.chk_err = 1'b0;
        s.code    = CC_GET;
        s.wr_data = 1'b0;
        s.nxt     = ph;
        echo      = (ph == ST_WR_FIRST) ? SC_WRS : SC_WRN;
        case (ph)
            ST_GET: s.nxt = ST_CHK_RDY;
            ST_CHK_RDY: begin
                if (sts != SC_RDY) s.recover = 1'b1;
                else begin
                    s.code = CC_WRS; s.wr_data = 1'b1; s.nxt = ST_WR_FIRST;
                end
            end
            ST_WR_FIRST, ST_WR_MID: begin
                if (sts != echo) s.recover = 1'b1;
                else if (!flg[F_TXR]) s.hold = 1'b1;
                else begin
                    s.code    = last ? CC_WRE : CC_WRN;
                    s.wr_data = 1'b1;
                    s.nxt     = last ? ST_WR_LAST : ST_WR_MID;
                end
            end
            ST_WR_LAST: begin
                if (sts != SC_WRE) s.recover = 1'b1;
                else begin
                    s.rd_data = 1'b1; s.chk_err = 1'b1; s.nxt = ST_TURN;
                end
            end
            ST_TURN: begin
                if (!flg[F_RXR]) s.hold = 1'b1;
                else begin
                    s.code = CC_RDS; s.nxt = ST_RD_FIRST;
                end
            end
            ST_RD_FIRST: begin
                if (sts != SC_RDS) s.recover = 1'b1;
                else if (!flg[F_RXR]) s.hold = 1'b1;
                else begin
                    s.rd_data = 1'b1; s.code = CC_RDN; s.nxt = ST_RD_MID;
                end
            end
            ST_RD_MID: begin
                if (sts == SC_RDE) begin
                    s.rd_data = 1'b1; s.code = CC_RDE; s.nxt = ST_RD_LAST;
                end else if (sts != SC_RDN) s.recover = 1'b1;
                else if (!flg[F_RXR]) s.hold = 1'b1;
                else begin
                    s.rd_data = 1'b1; s.code = CC_RDN; s.nxt = ST_RD_MID;
                end
            end
            ST_RD_LAST: begin
                if (sts != SC_RDY) s.recover = 1'b1;
                else begin
                    s.rd_data = 1'b1; s.chk_err = 1'b1; s.nxt = ST_IDLE;
                end
            end
            default: s.recover = 1'b1;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/smic_tmo_timer.sv
module smic_tmo_timer #(
    parameter int CLK_MHZ = 100,
    parameter int TMO_US  = 2000000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic kick,
    output logic expired
);
    localparam int PRE_W = $clog2(CLK_MHZ + 1);
    localparam int CNT_W = $clog2(TMO_US + 1);

    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cnt;
    logic             us_tick;

    assign us_tick = (pre == PRE_W'(CLK_MHZ - 1));

    always_ff @(posedge clk) begin
        if (rst || kick || !en) begin
            pre     <= '0;
            cnt     <= CNT_W'(TMO_US);
            expired <= 1'b0;
        end else begin
            pre <= us_tick ? '0 : pre + 1'b1;
            if (us_tick) begin
                if (cnt == '0) expired <= 1'b1;
                else           cnt     <= cnt - 1'b1;
            end
        end
    end

    AST_TMO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!en || kick) |=> !expired) else $error("timer expired while held"); // R9
endmodule

// File: rtl/smic_retry_ctr.sv
module smic_retry_ctr #(
    parameter int MAX_RETRY = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic exhausted
);
    localparam int RW = $clog2(MAX_RETRY + 2);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (inc && !exhausted) cnt <= cnt + 1'b1;
    end

    assign exhausted = (cnt >= RW'(MAX_RETRY));

    AST_RETRY_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt <= RW'(MAX_RETRY)) else $error("retry count overrun"); // R8
endmodule

// File: rtl/smic_proto_fsm.sv
module smic_proto_fsm
    import smic_pkg::*;
#(
    parameter int MAX_LEN = 80,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] req_len,
    output logic             start_rej,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             attn,
    output logic [LEN_W-1:0] req_addr,
    input  logic [7:0]       req_data,
    output logic             resp_we,
    output logic [LEN_W-1:0] resp_addr,
    output logic [7:0]       resp_data,
    output logic [LEN_W-1:0] resp_len,
    output logic             resp_trunc,
    output logic [1:0]       bus_addr,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_rdata,
    output logic             tmo_en,
    output logic             tmo_kick,
    input  logic             tmo_exp,
    output logic             rty_clr,
    output logic             rty_inc,
    input  logic             rty_exh
);
    phase_e           ph;
    micro_e           ms;
    step_t            dec, d_now;
    logic [7:0]       flg;
    logic [LEN_W-1:0] len, wptr, rcnt;
    logic             last, start_ok, recover, commit, has_room;

    assign last      = ((len - wptr) == LEN_W'(1));
    assign has_room  = (rcnt < LEN_W'(MAX_LEN));
    assign d_now     = decide(ph, bus_rdata, flg, last);
    assign start_ok  = start && (ph == ST_IDLE || ph == ST_DEAD) &&
                       req_len >= LEN_W'(2) && req_len <= LEN_W'(MAX_LEN);
    assign busy      = (ph != ST_IDLE);
    assign tmo_en    = (ph != ST_IDLE) && (ph != ST_DEAD);
    assign req_addr  = wptr;
    assign resp_addr = rcnt;
    assign resp_data = bus_rdata;
    assign resp_len  = rcnt;
    assign resp_we   = (ms == MS_RDDATA) && !dec.chk_err && has_room;

    always_comb begin
        recover = 1'b0;
        commit  = 1'b0;
        if (!start_ok && tmo_en) begin
            case (ms)
                MS_POLL:   recover = tmo_exp;
                MS_STATUS: recover = d_now.recover;
                MS_RDDATA: if (dec.chk_err) begin
                               recover = (bus_rdata != 8'h00);
                               commit  = (bus_rdata == 8'h00);
                           end
                MS_FLAGS:  commit = 1'b1;
                default:   ;
            endcase
        end
    end

    assign tmo_kick = start_ok || recover || commit;
    assign rty_inc  = recover;
    assign rty_clr  = start_ok;

    always_comb begin
        bus_addr  = A_FLG;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_wdata = 8'h00;
        case (ms)
            MS_POLL:   bus_rd = (ph != ST_DEAD);
            MS_STATUS: begin bus_rd = 1'b1; bus_addr = A_CTRL; end
            MS_RDDATA: begin bus_rd = 1'b1; bus_addr = A_DATA; end
            MS_CTRL:   begin bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = dec.code; end
            MS_WDATA:  begin bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = req_data; end
            MS_FLAGS:  begin bus_wr = 1'b1; bus_wdata = flg | 8'h01; end
            default:   ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= ST_IDLE; ms <= MS_POLL; flg <= '0; len <= '0;
            wptr <= '0; rcnt <= '0; resp_trunc <= 1'b0; attn <= 1'b0;
            done <= 1'b0; fail <= 1'b0; start_rej <= 1'b0;
            dec <= decide(ST_IDLE, 8'h00, 8'h00, 1'b0);
        end else begin
            done      <= 1'b0;
            fail      <= 1'b0;
            start_rej <= start && !start_ok;
            if (start_ok) begin
                ph <= ST_GET; ms <= MS_POLL; len <= req_len;
                wptr <= '0; rcnt <= '0; resp_trunc <= 1'b0; attn <= 1'b0;
            end else if (ph == ST_DEAD) begin
                fail <= 1'b1; ph <= ST_IDLE; ms <= MS_POLL;
            end else if (recover) begin
                wptr <= '0; rcnt <= '0; resp_trunc <= 1'b0; ms <= MS_POLL;
                ph   <= rty_exh ? ST_DEAD : ST_GET;
            end else begin
                case (ms)
                    MS_POLL: begin
                        flg <= bus_rdata;
                        if (!bus_rdata[F_BSY]) begin
                            if (ph == ST_IDLE) attn <= bus_rdata[F_MSG];
                            else               ms   <= MS_STATUS;
                        end
                    end
                    MS_STATUS: begin
                        dec <= d_now;
                        if (d_now.hold)         ms <= MS_POLL;
                        else if (d_now.rd_data) ms <= MS_RDDATA;
                        else                    ms <= MS_CTRL;
                    end
                    MS_RDDATA: begin
                        if (dec.chk_err) begin
                            ph <= dec.nxt; ms <= MS_POLL;
                            if (dec.nxt == ST_IDLE) done <= 1'b1;
                        end else begin
                            if (has_room) rcnt <= rcnt + 1'b1;
                            else          resp_trunc <= 1'b1;
                            ms <= MS_CTRL;
                        end
                    end
                    MS_CTRL:  ms <= dec.wr_data ? MS_WDATA : MS_FLAGS;
                    MS_WDATA: begin wptr <= wptr + 1'b1; ms <= MS_FLAGS; end
                    MS_FLAGS: begin ph <= dec.nxt; ms <= MS_POLL; end
                    default:  ms <= MS_POLL;
                endcase
            end
        end
    end

    AST_BSY_HOLDOFF: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_FLG && bus_rdata[F_BSY]) |=>
        (!bus_wr && (!bus_rd || bus_addr == A_FLG))) else $error("access while busy"); // R3
    AST_CTRL_THEN_MORE: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CTRL) |=> (bus_wr && bus_addr != A_CTRL))
        else $error("control write not followed by data/flags"); // R4
    AST_FLAGS_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_FLG) |-> $past(bus_wr)) else $error("lone flags write"); // R4
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && fail)) else $error("done with fail"); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done wider than one cycle"); // R12
    AST_RESP_BOUND: assert property (@(posedge clk) disable iff (rst)
        resp_we |-> (resp_addr < LEN_W'(MAX_LEN))) else $error("store past buffer"); // R10
    AST_ATTN_IDLE: assert property (@(posedge clk) disable iff (rst)
        attn |-> !busy) else $error("attn while busy"); // R11
endmodule

// File: rtl/smic_host_ctrl.sv
module smic_host_ctrl #(
    parameter int MAX_LEN   = 80,
    parameter int CLK_MHZ   = 100,
    parameter int TMO_US    = 2000000,
    parameter int MAX_RETRY = 3,
    localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] req_len,
    output logic             start_rej,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic             attn,
    output logic [LEN_W-1:0] req_addr,
    input  logic [7:0]       req_data,
    output logic             resp_we,
    output logic [LEN_W-1:0] resp_addr,
    output logic [7:0]       resp_data,
    output logic [LEN_W-1:0] resp_len,
    output logic             resp_trunc,
    output logic [1:0]       bus_addr,
    output logic             bus_rd,
    output logic             bus_wr,
    output logic [7:0]       bus_wdata,
    input  logic [7:0]       bus_rdata
);
    logic tmo_en, tmo_kick, tmo_exp, rty_clr, rty_inc, rty_exh;

    smic_tmo_timer #(.CLK_MHZ(CLK_MHZ), .TMO_US(TMO_US)) u_tmo (
        .clk(clk), .rst(rst), .en(tmo_en), .kick(tmo_kick), .expired(tmo_exp));

    smic_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_rty (
        .clk(clk), .rst(rst), .clr(rty_clr), .inc(rty_inc), .exhausted(rty_exh));

    smic_proto_fsm #(.MAX_LEN(MAX_LEN)) u_fsm (
        .clk(clk), .rst(rst), .start(start), .req_len(req_len),
        .start_rej(start_rej), .busy(busy), .done(done), .fail(fail), .attn(attn),
        .req_addr(req_addr), .req_data(req_data),
        .resp_we(resp_we), .resp_addr(resp_addr), .resp_data(resp_data),
        .resp_len(resp_len), .resp_trunc(resp_trunc),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmo_en(tmo_en), .tmo_kick(tmo_kick), .tmo_exp(tmo_exp),
        .rty_clr(rty_clr), .rty_inc(rty_inc), .rty_exh(rty_exh));
endmodule

// File: tb/smic_host_ctrl_tb.sv
module smic_host_ctrl_tb_top;
    localparam int MAXL = 80;
    localparam int LW   = $clog2(MAXL + 1);

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [LW-1:0] req_len = '0;
    logic start_rej, busy, done, fail, attn, resp_we, resp_trunc, bus_rd, bus_wr;
    logic [LW-1:0] req_addr, resp_addr, resp_len;
    logic [7:0] req_data, resp_data, bus_wdata, bus_rdata;
    logic [1:0] bus_addr;

    always #5 clk = ~clk;

    smic_host_ctrl #(.MAX_LEN(MAXL), .CLK_MHZ(10), .TMO_US(6), .MAX_RETRY(3)) dut_i (
        .clk(clk), .rst(rst), .start(start), .req_len(req_len), .start_rej(start_rej),
        .busy(busy), .done(done), .fail(fail), .attn(attn),
        .req_addr(req_addr), .req_data(req_data), .resp_we(resp_we),
        .resp_addr(resp_addr), .resp_data(resp_data), .resp_len(resp_len),
        .resp_trunc(resp_trunc), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    function automatic logic [7:0] qbyte(int s, int i);
        return 8'((i * 13 + s * 31 + 1) & 255);
    endfunction
    function automatic logic [7:0] rbyte(int s, int i);
        return 8'((i * 7 + s * 29 + 3) & 255);
    endfunction

    // configuration, driven only by the stimulus process
    int cfg_seed = 0, cfg_rlen = 2, cfg_bad = 0, cfg_gate = 0, cfg_we = 0, cfg_re = 0;
    logic m_clr = 1'b0, m_stuck = 1'b0, m_sms = 1'b0, m_extra = 1'b0;

    // register model state, driven only by the model process
    logic [7:0] m_status = 8'hC0, m_data = 8'h00, m_ctrl = 8'h00;
    logic m_busy = 1'b0;
    int m_bcnt = 0, m_gcnt = 0, n_get = 0, n_we = 0, n_re = 0, ridx = 0, widx = 0;
    int gate_viol = 0, stuck_acc = 0;
    logic [7:0] cap [0:MAXL-1];
    logic [7:0] got [0:MAXL-1];
    logic rdy;

    assign rdy      = (m_gcnt == 0);
    assign req_data = qbyte(cfg_seed, int'(req_addr));
    always_comb begin
        case (bus_addr)
            2'd0:    bus_rdata = m_data;
            2'd1:    bus_rdata = m_status;
            2'd2:    bus_rdata = {rdy, rdy, 1'b0, m_extra, m_extra, m_sms, 1'b0, m_busy | m_stuck};
            default: bus_rdata = 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (m_clr) begin
            n_get <= 0; n_we <= 0; n_re <= 0; gate_viol <= 0; stuck_acc <= 0;
        end
        if (m_busy) begin
            if (m_bcnt > 0) m_bcnt <= m_bcnt - 1;
            else begin m_busy <= 1'b0; m_gcnt <= cfg_gate; end
        end else if (m_gcnt > 0) m_gcnt <= m_gcnt - 1;
        if (m_stuck && (bus_wr || (bus_rd && bus_addr != 2'd2))) stuck_acc <= stuck_acc + 1;
        if (resp_we) got[resp_addr] <= resp_data;
        if (bus_wr && bus_addr == 2'd1) begin
            m_ctrl <= bus_wdata;
            if (bus_wdata == 8'h41) widx <= 0;
            if ((bus_wdata == 8'h42 || bus_wdata == 8'h43 || bus_wdata == 8'h44 ||
                 bus_wdata == 8'h45) && !rdy) gate_viol <= gate_viol + 1;
        end
        if (bus_wr && bus_addr == 2'd0) begin
            if (widx < MAXL) cap[widx] <= bus_wdata;
            widx <= widx + 1;
        end
        if (bus_wr && bus_addr == 2'd2 && bus_wdata[0]) begin
            m_busy <= 1'b1; m_bcnt <= 2;
            case (m_ctrl)
                8'h40: begin m_status <= (n_get < cfg_bad) ? 8'hC1 : 8'hC0; n_get <= n_get + 1; end
                8'h41: m_status <= 8'hC1;
                8'h42: m_status <= 8'hC2;
                8'h43: begin
                    m_status <= 8'hC3; m_data <= (n_we < cfg_we) ? 8'h05 : 8'h00;
                    n_we <= n_we + 1;
                end
                8'h44: begin m_status <= 8'hC4; ridx <= 0; m_data <= rbyte(cfg_seed, 0); end
                8'h45: begin
                    ridx <= ridx + 1; m_data <= rbyte(cfg_seed, ridx + 1);
                    m_status <= (ridx + 1 == cfg_rlen - 1) ? 8'hC6 : 8'hC5;
                end
                8'h46: begin
                    m_status <= 8'hC0; m_data <= (n_re < cfg_re) ? 8'h05 : 8'h00;
                    n_re <= n_re + 1;
                end
                default: m_status <= 8'hC0;
            endcase
        end
    end

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_start(int len);
        @(negedge clk); start = 1'b1; req_len = LW'(len);
        @(negedge clk); start = 1'b0;
    endtask

    task automatic clear_model();
        @(negedge clk); m_clr = 1'b1;
        @(negedge clk); m_clr = 1'b0;
    endtask

    // 0 = timeout, 1 = done, 2 = fail
    task automatic wait_end(output int res);
        res = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done || fail) begin
                res = done ? 1 : 2;
                @(negedge clk);
                chk(!done && !fail, "R12 single pulse", int'(done | fail), 0);
                break;
            end
        end
    endtask

    task automatic check_data(int qlen, int rlen, string req);
        int nbad = 0;
        int keep = (rlen > MAXL) ? MAXL : rlen;
        for (int i = 0; i < qlen; i++) if (cap[i] !== qbyte(cfg_seed, i)) nbad++;
        chk(nbad == 0, {req, " request bytes"}, nbad, 0);
        chk(widx == qlen, {req, " request count"}, widx, qlen);
        nbad = 0;
        for (int i = 0; i < keep; i++) if (got[i] !== rbyte(cfg_seed, i)) nbad++;
        chk(nbad == 0, {req, " response bytes"}, nbad, 0);
        chk(int'(resp_len) == keep, {req, " resp_len"}, int'(resp_len), keep);
        chk(resp_trunc == (rlen > MAXL), "R10 trunc flag", int'(resp_trunc), int'(rlen > MAXL));
        chk(gate_viol == 0, "R5 R6 ready gating", gate_viol, 0);
    endtask

    typedef struct packed {
        logic [7:0] qlen;
        logic [7:0] rlen;
        logic [3:0] bad;
        logic [3:0] gate;
        logic [3:0] we;
        logic [3:0] re;
        logic       ok;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd2,  8'd2,  4'd0, 4'd0, 4'd0, 4'd0, 1'b1},
        '{8'd5,  8'd6,  4'd1, 4'd3, 4'd0, 4'd0, 1'b1},
        '{8'd80, 8'd80, 4'd0, 4'd0, 4'd0, 4'd0, 1'b1},
        '{8'd3,  8'd85, 4'd0, 4'd1, 4'd0, 4'd0, 1'b1},
        '{8'd4,  8'd3,  4'd0, 4'd2, 4'd1, 4'd0, 1'b1},
        '{8'd4,  8'd3,  4'd0, 4'd0, 4'd0, 4'd2, 1'b1},
        '{8'd6,  8'd4,  4'd3, 4'd0, 4'd0, 4'd0, 1'b1},
        '{8'd3,  8'd3,  4'd4, 4'd0, 4'd0, 4'd0, 1'b0},
        '{8'd3,  8'd5,  4'd2, 4'd0, 4'd1, 4'd1, 1'b0}
    };

    initial begin
        #1500000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int res;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !fail && !attn && !start_rej, "R1 reset outputs",
            int'({busy, done, fail, attn, start_rej}), 0);
        chk(!bus_wr && resp_len == 0 && !resp_trunc, "R1 reset bus/len",
            int'({bus_wr, resp_trunc}) + int'(resp_len), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy, "R1 idle after reset", int'(busy), 0);

        // table walk: R5 R6 R7 R8 R10
        for (int v = 0; v < NV; v++) begin
            cfg_seed = v + 1; cfg_rlen = int'(VECS[v].rlen); cfg_bad = int'(VECS[v].bad);
            cfg_gate = int'(VECS[v].gate); cfg_we = int'(VECS[v].we); cfg_re = int'(VECS[v].re);
            clear_model();
            do_start(int'(VECS[v].qlen));
            chk(!start_rej, "R2 valid start accepted", int'(start_rej), 0);
            wait_end(res);
            chk(res == (VECS[v].ok ? 1 : 2), VECS[v].ok ? "R7 completes" : "R8 retry limit fail",
                res, VECS[v].ok ? 1 : 2);
            if (VECS[v].ok) check_data(int'(VECS[v].qlen), cfg_rlen, "R5 R7");
            repeat (3) @(negedge clk);
            chk(!busy, "R8 idle after exchange", int'(busy), 0);
        end

        // R2 length bounds
        do_start(1);
        chk(start_rej && !busy, "R2 reject len 1", int'(start_rej), 1);
        do_start(81);
        chk(start_rej && !busy, "R2 reject len 81", int'(start_rej), 1);

        // R2 start while busy is refused and the running exchange is untouched
        cfg_seed = 20; cfg_rlen = 4; cfg_bad = 0; cfg_gate = 1; cfg_we = 0; cfg_re = 0;
        clear_model();
        do_start(5);
        repeat (6) @(negedge clk);
        do_start(3);
        chk(start_rej, "R2 reject while busy", int'(start_rej), 1);
        wait_end(res);
        chk(res == 1, "R2 exchange survives refused start", res, 1);
        check_data(5, 4, "R2");

        // R9 stuck busy: timeouts exhaust retries, nothing touched while busy (R3)
        cfg_seed = 21;
        clear_model();
        m_stuck = 1'b1;
        do_start(3);
        wait_end(res);
        chk(res == 2, "R9 stuck busy ends in fail", res, 2);
        chk(stuck_acc == 0, "R3 no access while busy", stuck_acc, 0);
        m_stuck = 1'b0;
        repeat (5) @(negedge clk);

        // R11 attention and ignored flag bits
        m_extra = 1'b1;
        repeat (5) @(negedge clk);
        chk(!attn, "R11 bits 4/3 ignored", int'(attn), 0);
        m_sms = 1'b1;
        repeat (5) @(negedge clk);
        chk(attn, "R11 attn raised", int'(attn), 1);
        m_sms = 1'b0; m_extra = 1'b0;
        repeat (5) @(negedge clk);
        chk(!attn, "R11 attn cleared", int'(attn), 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule